// File: doc/BRIEF.md
# Two-Channel DMA Bus Arbiter

This block decides which of two DMA channels, one moving received data and one moving data to transmit, owns the system bus. It raises a single bus request toward the system and waits for a grant. The grant comes along a daisy chain: when the block has no channel to serve, it passes the incoming grant on to the next master downstream. Once it holds the grant, it gives a per-channel grant to one channel. That channel keeps the bus for one tenure.

Channel priority is either fixed or alternating. In alternating mode the favoured channel flips after every grant. An optional preempt setting lets the favoured channel take the bus from the other channel in mid-tenure. A tenure ends in several ways: the owning channel stops requesting, its FIFO reaches the level at which it must stop (receive FIFO empty, transmit FIFO full), the upstream grant goes away, or a dwell limit is reached. The dwell limit can count transfers, clock cycles, or both. When a tenure ends, the bus either passes straight to the other channel or is released. After a release, a programmable off-bus gap must pass before the block requests the bus again.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After reset, bus_req, rx_gnt, tx_gnt and grant_out are all 0.
- R2: With cfg_rotate=0, when both channels are eligible at the moment the grant is taken, the transmit channel wins if cfg_tx_first=1 and the receive channel wins if cfg_tx_first=0. A channel grant lasts the whole tenure.
- R3: With cfg_rotate=1, the favoured channel is the one that was not granted last. The receive channel is favoured first after reset. So with both channels always eligible, successive grants go receive, transmit, receive.
- R4: With cfg_preempt=1, when the channel that currently has priority becomes eligible while the other channel holds the bus, ownership moves to it one cycle later and bus_req stays 1. With cfg_preempt=0, the holder keeps the bus.
- R5: When a tenure ends while the grant is still present and the other channel is eligible, cfg_handoff=1 moves the grant to the other channel in the next cycle and bus_req stays 1. cfg_handoff=0 releases the bus (bus_req goes to 0).
- R6: cfg_fifo_stop bit 0 set makes the receive channel ineligible while rx_fifo_empty=1. Bit 1 set makes the transmit channel ineligible while tx_fifo_full=1. An ineligible channel does not cause a request. If it owns the bus, its tenure ends and its grant drops one cycle later. With the bit clear, the flag is ignored.
- R7: With cfg_dwell_mode bit 0 set, a tenure ends on the cycle of transfer number cfg_xfer_limit (xfer_stb high). The grant and bus_req drop in the next cycle, so with xfer_stb held high the grant lasts cfg_xfer_limit cycles.
- R8: With cfg_dwell_mode bit 1 set, a grant lasts at most cfg_clk_limit cycles (limit 0 behaves as 1).
- R9: With both dwell bits set, the tenure ends at whichever of the two limits is reached first.
- R10: While the block has no eligible channel, a present grant_in is passed on as grant_out one cycle later. Once passed, grant_out follows grant_in and the block does not request until grant_in falls, even if a channel becomes eligible.
- R11: A channel grant is given only in a cycle after grant_in was seen high while bus_req was high. At most one channel grant is high at a time.
- R12: After a release, bus_req stays 0 for cfg_off_delay + 1 cycles before it can rise again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_req | input | 1 | Receive channel wants the bus |
| tx_req | input | 1 | Transmit channel wants the bus |
| rx_fifo_empty | input | 1 | Receive FIFO has no data |
| tx_fifo_full | input | 1 | Transmit FIFO has no room |
| xfer_stb | input | 1 | One bus transfer by the owning channel this cycle |
| grant_in | input | 1 | Daisy-chain grant from upstream |
| grant_out | output | 1 | Daisy-chain grant passed downstream |
| bus_req | output | 1 | Bus request to the system |
| rx_gnt | output | 1 | Receive channel owns the bus |
| tx_gnt | output | 1 | Transmit channel owns the bus |
| cfg_rotate | input | 1 | 1: alternating priority |
| cfg_tx_first | input | 1 | Fixed priority: 1 favours transmit |
| cfg_preempt | input | 1 | Allow takeover by the favoured channel |
| cfg_handoff | input | 1 | 1: hand the bus to the other channel at tenure end |
| cfg_fifo_stop | input | 2 | bit0: stop receive on empty, bit1: stop transmit on full |
| cfg_dwell_mode | input | 2 | bit0: count transfers, bit1: count clocks |
| cfg_xfer_limit | input | CNT_W | Transfer limit per tenure |
| cfg_clk_limit | input | CNT_W | Clock limit per tenure |
| cfg_off_delay | input | OFF_W | Off-bus gap in clocks after release |

## Verification
The bench builds the arbiter with CNT_W=4 and OFF_W=3. With these values the largest clock dwell (15) and the largest off-bus gap (7) can be reached in a few cycles, along with limit values at both ends of their range. Random phases with small widths also hit the zero limits, zero gap and limit-equals-count corners often. They also cover preempt combined with alternating priority, grants arriving while a handoff is pending, and upstream grants removed in mid-tenure.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_OWN  = 3'd2,
    ST_OFF  = 3'd3,
    ST_PASS = 3'd4
  } arb_state_e;
endpackage

// File: rtl/dma_arb_prio.sv
module dma_arb_prio (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_rotate,
  input  logic cfg_tx_first,
  input  logic elig_rx,
  input  logic elig_tx,
  input  logic grant_evt,
  input  logic granted_tx,
  output logic hi_tx,
  output logic pick_tx
);
  logic last_rx;

  // alternating mode favours whichever channel did not win last time
  assign hi_tx   = cfg_rotate ? last_rx : cfg_tx_first;
  assign pick_tx = elig_tx & (~elig_rx | hi_tx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         last_rx <= 1'b0;
    else if (grant_evt) last_rx <= ~granted_tx;
  end

  // R3: after a grant in alternating mode, the other channel is favoured
  a_r3_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rotate && grant_evt) |=> (!cfg_rotate || (hi_tx == !$past(granted_tx))));
  // R2: a lone eligible channel is always picked
  a_r2_lone_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_tx && !elig_rx) |-> pick_tx);
endmodule

// File: rtl/dma_arb_dwell.sv
module dma_arb_dwell #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_tenure,
  input  logic             stay,
  input  logic             xfer_stb,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] xfer_lim,
  input  logic [CNT_W-1:0] clk_lim,
  output logic             hit
);
  localparam int CW1 = CNT_W + 1;
  localparam logic [CNT_W-1:0] C_ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CW1-1:0]   W_ONE = {{CNT_W{1'b0}}, 1'b1};

  logic [CNT_W-1:0] xcnt, ccnt;
  logic xfer_hit, clk_hit;

  // true when the event of this cycle brings the count to the limit
  function automatic logic reaches(input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] lim);
    return ({1'b0, cnt} + W_ONE) >= {1'b0, lim};
  endfunction

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v,
                                            input logic en);
    return (en && (v != {CNT_W{1'b1}})) ? v + C_ONE : v;
  endfunction

  assign xfer_hit = mode[0] & xfer_stb & reaches(xcnt, xfer_lim);
  assign clk_hit  = mode[1] & reaches(ccnt, clk_lim);
  assign hit      = in_tenure & (xfer_hit | clk_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xcnt <= '0;
      ccnt <= '0;
    end else if (stay) begin
      xcnt <= bump(xcnt, xfer_stb);
      ccnt <= bump(ccnt, 1'b1);
    end else begin
      xcnt <= '0;
      ccnt <= '0;
    end
  end

  // R9: a reached limit always starts the next tenure from zero
  a_r9_restart_after_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (xcnt == '0 && ccnt == '0));
  // R8: counting happens only while a tenure runs
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_tenure) |-> (ccnt == '0));
endmodule

// File: rtl/dma_arb_offtimer.sv
module dma_arb_offtimer #(
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFF_W-1:0] delay,
  output logic             last
);
  localparam logic [OFF_W-1:0] O_ONE = {{(OFF_W-1){1'b0}}, 1'b1};
  logic [OFF_W-1:0] cnt;

  assign last = (cnt == O_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= delay;
    else if (cnt != '0)    cnt <= cnt - O_ONE;
  end

  // R12: once loaded the gap counts down one per clock
  a_r12_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) != '0 && !$past(load)) |-> (cnt == $past(cnt) - O_ONE));
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int OFF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_req,
  input  logic             tx_req,
  input  logic             rx_fifo_empty,
  input  logic             tx_fifo_full,
  input  logic             xfer_stb,
  input  logic             grant_in,
  output logic             grant_out,
  output logic             bus_req,
  output logic             rx_gnt,
  output logic             tx_gnt,
  input  logic             cfg_rotate,
  input  logic             cfg_tx_first,
  input  logic             cfg_preempt,
  input  logic             cfg_handoff,
  input  logic [1:0]       cfg_fifo_stop,
  input  logic [1:0]       cfg_dwell_mode,
  input  logic [CNT_W-1:0] cfg_xfer_limit,
  input  logic [CNT_W-1:0] cfg_clk_limit,
  input  logic [OFF_W-1:0] cfg_off_delay
);
  arb_state_e state, state_nx;
  logic own_tx, own_tx_nx;
  logic elig_rx, elig_tx, any_elig;
  logic hi_tx, pick_tx;
  logic own_elig, oth_elig;
  logic dwell_hit, end_now, preempt_now;
  logic switch_now, release_now, take_now;
  logic grant_evt, stay, off_load, off_last, in_tenure;

  // named events for checking
  assign elig_rx  = rx_req & ~(cfg_fifo_stop[0] & rx_fifo_empty);
  assign elig_tx  = tx_req & ~(cfg_fifo_stop[1] & tx_fifo_full);
  assign any_elig = elig_rx | elig_tx;

  assign in_tenure   = (state == ST_OWN);
  assign own_elig    = own_tx ? elig_tx : elig_rx;
  assign oth_elig    = own_tx ? elig_rx : elig_tx;
  assign end_now     = in_tenure & (~grant_in | ~own_elig | dwell_hit);
  assign preempt_now = in_tenure & cfg_preempt & oth_elig & (hi_tx != own_tx);
  assign take_now    = (state == ST_REQ) & any_elig & grant_in;

  always_comb begin
    state_nx    = state;
    own_tx_nx   = own_tx;
    switch_now  = 1'b0;
    release_now = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (any_elig)      state_nx = ST_REQ;
        else if (grant_in) state_nx = ST_PASS;
      end
      ST_REQ: begin
        if (!any_elig) state_nx = ST_IDLE;
        else if (grant_in) begin
          state_nx  = ST_OWN;
          own_tx_nx = pick_tx;
        end
      end
      ST_OWN: begin
        if (end_now) begin
          if (grant_in && cfg_handoff && oth_elig) switch_now = 1'b1;
          else begin
            release_now = 1'b1;
            state_nx    = (cfg_off_delay == '0) ? ST_IDLE : ST_OFF;
          end
        end else if (preempt_now) begin
          switch_now = 1'b1;
        end
        if (switch_now) own_tx_nx = ~own_tx;
      end
      ST_OFF:  if (off_last)  state_nx = ST_IDLE;
      ST_PASS: if (!grant_in) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  assign grant_evt = take_now | switch_now;
  assign stay      = in_tenure & ~end_now & ~switch_now;
  assign off_load  = release_now & (cfg_off_delay != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      own_tx <= 1'b0;
    end else begin
      state  <= state_nx;
      own_tx <= own_tx_nx;
    end
  end

  assign bus_req   = (state == ST_REQ) | (state == ST_OWN);
  assign rx_gnt    = in_tenure & ~own_tx;
  assign tx_gnt    = in_tenure & own_tx;
  assign grant_out = (state == ST_PASS) & grant_in;

  dma_arb_prio u_prio (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_rotate   (cfg_rotate),
    .cfg_tx_first (cfg_tx_first),
    .elig_rx      (elig_rx),
    .elig_tx      (elig_tx),
    .grant_evt    (grant_evt),
    .granted_tx   (own_tx_nx),
    .hi_tx        (hi_tx),
    .pick_tx      (pick_tx)
  );

  dma_arb_dwell #(.CNT_W(CNT_W)) u_dwell (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_tenure (in_tenure),
    .stay      (stay),
    .xfer_stb  (xfer_stb),
    .mode      (cfg_dwell_mode),
    .xfer_lim  (cfg_xfer_limit),
    .clk_lim   (cfg_clk_limit),
    .hit       (dwell_hit)
  );

  dma_arb_offtimer #(.OFF_W(OFF_W)) u_off (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (off_load),
    .delay (cfg_off_delay),
    .last  (off_last)
  );

  // R11: a channel grant follows a seen upstream grant
  a_r11_gnt_after_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_gnt || tx_gnt) |-> $past(grant_in));
  // R10: a grant handed downstream is kept while upstream keeps it
  a_r10_keep_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(grant_out) && grant_in) |-> (grant_out && !bus_req));
  // R7: a released tenure drops request and grants in the next cycle
  a_r7_tenure_drop: assert property (@(posedge clk) disable iff (!rst_n)
    release_now |=> (!bus_req && !rx_gnt && !tx_gnt));
  // R4: a preempt moves ownership while the bus is kept
  a_r4_preempt_take: assert property (@(posedge clk) disable iff (!rst_n)
    (preempt_now && !end_now) |=> (bus_req && (tx_gnt == !$past(tx_gnt))));
  // R12: a nonzero gap keeps the request low one more cycle after release
  a_r12_off_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_req) && $past(rx_gnt || tx_gnt) && cfg_off_delay != '0) |=> !bus_req);
endmodule

// File: tb/dma_bus_arbiter_test.sv
module dma_bus_arbiter_test;
  localparam int CNT_W = 4;
  localparam int OFF_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_req, tx_req, rx_fifo_empty, tx_fifo_full, xfer_stb, grant_in;
  logic grant_out, bus_req, rx_gnt, tx_gnt;
  logic cfg_rotate, cfg_tx_first, cfg_preempt, cfg_handoff;
  logic [1:0] cfg_fifo_stop, cfg_dwell_mode;
  logic [CNT_W-1:0] cfg_xfer_limit, cfg_clk_limit;
  logic [OFF_W-1:0] cfg_off_delay;
  logic ext_want, ext_block;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_bus_arbiter #(.CNT_W(CNT_W), .OFF_W(OFF_W)) uut (
    .clk(clk), .rst_n(rst_n), .rx_req(rx_req), .tx_req(tx_req),
    .rx_fifo_empty(rx_fifo_empty), .tx_fifo_full(tx_fifo_full),
    .xfer_stb(xfer_stb), .grant_in(grant_in), .grant_out(grant_out),
    .bus_req(bus_req), .rx_gnt(rx_gnt), .tx_gnt(tx_gnt),
    .cfg_rotate(cfg_rotate), .cfg_tx_first(cfg_tx_first),
    .cfg_preempt(cfg_preempt), .cfg_handoff(cfg_handoff),
    .cfg_fifo_stop(cfg_fifo_stop), .cfg_dwell_mode(cfg_dwell_mode),
    .cfg_xfer_limit(cfg_xfer_limit), .cfg_clk_limit(cfg_clk_limit),
    .cfg_off_delay(cfg_off_delay)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // upstream bus owner: grants when asked or when another master wants it
  always @(negedge clk) begin
    #2;
    grant_in = (bus_req | ext_want) & ~ext_block;
  end

  // behavioural reference: 0 idle, 1 asking, 2 owning, 3 gap, 4 passed on
  int m_st, m_x, m_c, m_off;
  bit m_tx, m_last_rx;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_tx = 0; m_last_rx = 0; m_x = 0; m_c = 0; m_off = 0;
    end else begin
      bit er, et, hi, pick, oe, ot, hit, fin, sw;
      er = rx_req && !(cfg_fifo_stop[0] && rx_fifo_empty);
      et = tx_req && !(cfg_fifo_stop[1] && tx_fifo_full);
      hi = cfg_rotate ? m_last_rx : cfg_tx_first;
      pick = et && (!er || hi);
      sw = 0;
      if (m_st == 0) begin
        if (er || et) m_st = 1; else if (grant_in) m_st = 4;
      end else if (m_st == 1) begin
        if (!(er || et)) m_st = 0;
        else if (grant_in) begin
          m_st = 2; m_tx = pick; m_last_rx = !pick; m_x = 0; m_c = 0;
        end
      end else if (m_st == 2) begin
        oe = m_tx ? et : er;
        ot = m_tx ? er : et;
        hit = (cfg_dwell_mode[0] && xfer_stb && (m_x + 1 >= int'(cfg_xfer_limit))) ||
              (cfg_dwell_mode[1] && (m_c + 1 >= int'(cfg_clk_limit)));
        fin = !grant_in || !oe || hit;
        if (fin) begin
          if (grant_in && cfg_handoff && ot) sw = 1;
          else if (cfg_off_delay == 0) m_st = 0;
          else begin m_st = 3; m_off = int'(cfg_off_delay); end
        end else if (cfg_preempt && ot && (hi != m_tx)) sw = 1;
        else begin m_c++; if (xfer_stb) m_x++; end
        if (sw) begin m_tx = !m_tx; m_last_rx = !m_tx; m_x = 0; m_c = 0; end
      end else if (m_st == 3) begin
        if (m_off == 1) m_st = 0; else m_off--;
      end else begin
        if (!grant_in) m_st = 0;
      end
    end
  end

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(bus_req == (m_st == 1 || m_st == 2), "R7 bus_req vs model", bus_req, (m_st == 1 || m_st == 2));
      chk(rx_gnt == (m_st == 2 && !m_tx), "R2 rx_gnt vs model", rx_gnt, (m_st == 2 && !m_tx));
      chk(tx_gnt == (m_st == 2 && m_tx), "R2 tx_gnt vs model", tx_gnt, (m_st == 2 && m_tx));
      chk(grant_out == (m_st == 4 && grant_in), "R10 grant_out vs model", grant_out, (m_st == 4 && grant_in));
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rx_req = 0; tx_req = 0; rx_fifo_empty = 0; tx_fifo_full = 0; xfer_stb = 0;
    ext_want = 0; ext_block = 0;
    cfg_rotate = 0; cfg_tx_first = 0; cfg_preempt = 0; cfg_handoff = 0;
    cfg_fifo_stop = 2'b00; cfg_dwell_mode = 2'b00;
    cfg_xfer_limit = '0; cfg_clk_limit = '0; cfg_off_delay = '0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic wait_gnt(output int who);
    who = -1;
    for (int i = 0; i < 40; i++) begin
      step();
      if (rx_gnt) begin who = 0; break; end
      if (tx_gnt) begin who = 1; break; end
    end
  endtask

  task automatic hold_len(output int n);
    n = 0;
    while ((rx_gnt || tx_gnt) && n < 100) begin n++; step(); end
  endtask

  task automatic dwell_case(input logic [1:0] mode, input int xl, input int cl,
                            input bit stb, input int exp, input string tag);
    int who, n;
    do_reset();
    cfg_dwell_mode = mode;
    cfg_xfer_limit = CNT_W'(xl);
    cfg_clk_limit = CNT_W'(cl);
    xfer_stb = stb;
    rx_req = 1;
    wait_gnt(who);
    hold_len(n);
    chk(n == exp, tag, n, exp);
    chk(bus_req == 0, {tag, " bus_req low after last"}, bus_req, 0);
  endtask

  task automatic gap_case(input int d);
    int who, n, g;
    do_reset();
    cfg_off_delay = OFF_W'(d);
    cfg_dwell_mode = 2'b10; cfg_clk_limit = 2;
    rx_req = 1;
    wait_gnt(who);
    hold_len(n);
    g = 0;
    while (!bus_req && g < 50) begin g++; step(); end
    chk(g == d + 1, "R12 off gap length", g, d + 1);
  endtask

  initial begin
    int who, n;
    grant_in = 0;
    do_reset();
    // R1
    chk(bus_req == 0 && rx_gnt == 0 && tx_gnt == 0 && grant_out == 0,
        "R1 outputs after reset", {bus_req, rx_gnt, tx_gnt, grant_out}, 0);

    // R2 fixed priority, both ways
    rx_req = 1; tx_req = 1;
    wait_gnt(who);
    chk(who == 0, "R2 receive favoured", who, 0);
    do_reset();
    cfg_tx_first = 1; rx_req = 1; tx_req = 1;
    wait_gnt(who);
    chk(who == 1, "R2 transmit favoured", who, 1);

    // R11 no channel grant without upstream grant
    do_reset();
    ext_block = 1; rx_req = 1;
    step(6);
    chk(bus_req == 1 && !rx_gnt && !tx_gnt, "R11 wait for grant_in", {bus_req, rx_gnt, tx_gnt}, 4);
    ext_block = 0;
    wait_gnt(who);
    chk(who == 0, "R11 grant after grant_in", who, 0);

    // R7 R8 R9 dwell limits
    dwell_case(2'b01, 3, 0, 1, 3, "R7 transfer limit 3");
    dwell_case(2'b10, 0, 5, 0, 5, "R8 clock limit 5");
    dwell_case(2'b10, 0, 15, 0, 15, "R8 clock limit max");
    dwell_case(2'b10, 0, 0, 0, 1, "R8 clock limit zero");
    dwell_case(2'b11, 4, 6, 1, 4, "R9 transfers first");
    dwell_case(2'b11, 4, 6, 0, 6, "R9 clocks first");

    // R6 FIFO stop flags
    do_reset();
    cfg_fifo_stop = 2'b01; rx_req = 1; rx_fifo_empty = 1;
    step(5);
    chk(bus_req == 0, "R6 empty receive does not request", bus_req, 0);
    rx_fifo_empty = 0;
    wait_gnt(who);
    chk(who == 0, "R6 receive granted once not empty", who, 0);
    step(2);
    rx_fifo_empty = 1;
    step();
    chk(rx_gnt == 0, "R6 grant drops after empty", rx_gnt, 0);
    do_reset();
    cfg_fifo_stop = 2'b10; tx_req = 1; tx_fifo_full = 1;
    step(5);
    chk(bus_req == 0, "R6 full transmit does not request", bus_req, 0);
    cfg_fifo_stop = 2'b00;
    wait_gnt(who);
    chk(who == 1, "R6 full flag ignored when bit clear", who, 1);

    // R5 handoff versus release
    do_reset();
    cfg_handoff = 1; cfg_dwell_mode = 2'b10; cfg_clk_limit = 2;
    rx_req = 1; tx_req = 1;
    wait_gnt(who);
    step(2);
    chk(tx_gnt == 1 && bus_req == 1, "R5 handoff to transmit", {tx_gnt, bus_req}, 3);
    do_reset();
    cfg_dwell_mode = 2'b10; cfg_clk_limit = 2;
    rx_req = 1; tx_req = 1;
    wait_gnt(who);
    step(2);
    chk(bus_req == 0, "R5 release without handoff", bus_req, 0);

    // R4 preempt on and off
    do_reset();
    cfg_tx_first = 1; cfg_preempt = 1; rx_req = 1;
    wait_gnt(who);
    step(2);
    tx_req = 1;
    step();
    chk(tx_gnt == 1 && bus_req == 1, "R4 favoured channel takes over", {tx_gnt, bus_req}, 3);
    do_reset();
    cfg_tx_first = 1; rx_req = 1;
    wait_gnt(who);
    step(2);
    tx_req = 1;
    step(3);
    chk(rx_gnt == 1, "R4 holder keeps bus without preempt", rx_gnt, 1);

    // R3 alternating order
    do_reset();
    cfg_rotate = 1; cfg_dwell_mode = 2'b10; cfg_clk_limit = 1;
    rx_req = 1; tx_req = 1;
    for (int k = 0; k < 3; k++) begin
      wait_gnt(who);
      chk(who == (k % 2), "R3 alternating grant order", who, k % 2);
      hold_len(n);
    end

    // R12 gap after release
    gap_case(0);
    gap_case(4);
    gap_case(7);

    // R10 daisy chain pass-through
    do_reset();
    ext_want = 1;
    step(3);
    chk(grant_out == 1, "R10 grant passed on when idle", grant_out, 1);
    rx_req = 1;
    step(4);
    chk(grant_out == 1 && bus_req == 0, "R10 passed grant not taken back", {grant_out, bus_req}, 2);
    ext_want = 0;
    wait_gnt(who);
    chk(who == 0, "R10 request after downstream done", who, 0);

    // random phases, reference model compares every cycle
    for (int ph = 0; ph < 4; ph++) begin
      do_reset();
      cfg_rotate = ph[0]; cfg_tx_first = ph[1]; cfg_preempt = (ph != 1);
      cfg_handoff = (ph >= 2); cfg_fifo_stop = 2'(ph + 1);
      cfg_dwell_mode = 2'(ph); cfg_xfer_limit = CNT_W'(ph + 2);
      cfg_clk_limit = CNT_W'(ph * 3); cfg_off_delay = OFF_W'(ph);
      for (int i = 0; i < 2500; i++) begin
        rx_req = ($urandom % 4) != 0;
        tx_req = ($urandom % 3) != 0;
        rx_fifo_empty = ($urandom % 6) == 0;
        tx_fifo_full = ($urandom % 6) == 0;
        xfer_stb = $urandom % 2;
        ext_want = ($urandom % 10) == 0;
        ext_block = ($urandom % 25) == 0;
        step();
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R11 watchdog expired actual=0 expected=1");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule